// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block watches for a stalled program. A free-running 16-bit counter is split into a low byte and a high byte. It advances on each cycle where the tick input is high. Software programs an 8-bit offset. Software then services the watchdog with a kick write, which stores the counter's present high byte plus that offset into a match register. If software stops kicking, the counter's high byte eventually reaches the stored value. At the next wrap of the low byte, the block raises a single-cycle reset pulse.

A small three-state machine decides whether a wrap or a software force request turns into a pulse:
- State `WD_OFF`: the watchdog is disabled.
- State `WD_ARMED`: the watchdog is enabled and waiting.
- State `WD_FIRE`: the one cycle that produces the pulse.

Its transitions are:
- OFF→ARMED: a control write with the enable bit set.
- ARMED→OFF and FIRE→OFF: a control write with the enable bit clear.
- ARMED→FIRE: a matching wrap, or a control write with both enable and force set.
- FIRE→ARMED: every other case.

An idle-suspend setting lets a system idle signal freeze the counter. The intended bring-up order is: disable, program the offset, choose the idle behaviour, enable, then kick.

Top module: `cmp_watchdog`

## Requirements
- R1: After a synchronous reset the pulse output is low and the watchdog is enabled, with offset 0, match register 0 and counter 0. With no further writes, the first pulse follows the 256th advancing tick.
- R2: The counter advances by one only on cycles where `tick_i` is high and it is not suspended. The low byte carries into the high byte on its 0xFF→0x00 step.
- R3: A write to address 2 (a kick, with any data) loads the match register with the pre-write high byte plus the offset, modulo 256. A later kick replaces the earlier deadline.
- R4: When an advancing tick moves the low byte from 0xFF to 0x00 while the high byte equals the match register and the machine is in `WD_ARMED`, `wdt_rst_o` is high in the following cycle.
- R5: Counted in advancing ticks, including a tick at the kick's own edge, a pulse follows a kick after exactly 256·offset + 256 − L ticks, where L is the low byte at the kick.
- R6: A control write (address 0) with bit 0 (enable) and bit 2 (force) both set, made in `WD_ARMED`, raises `wdt_rst_o` in the next cycle.
- R7: In `WD_OFF` no pulse is produced; a matching wrap or a force bit has no effect. A control write with bit 0 clear moves the machine to `WD_OFF`, and this wins over a same-cycle expiry or force.
- R8: With control bit 1 (idle-suspend) set, cycles with `idle_i` high do not advance the counter, so the deadline moves out by those cycles. With bit 1 clear, `idle_i` has no effect.
- R9: Each pulse lasts exactly one clock cycle and comes straight from a register.
- R10: A write to address 1 sets the 8-bit offset. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Counter advance enable |
| idle_i | input | 1 | System idle indication |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 offset, 2 kick, 3 unused |
| bus_wdata_i | input | 8 | Write data; control uses bit 0 enable, bit 1 idle-suspend, bit 2 force |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
Writes take effect at the rising edge after the bus is driven, and a pulse appears one cycle after the edge that causes it. A forced pulse is therefore due exactly one cycle after the force write. A timeout pulse is due in the cycle after the advancing tick that completes 256·offset + 256 − L ticks. The driver queues each expectation either as an absolute cycle number (for force) or as a tick index (for kicks), taken from its own count of advancing ticks. The monitor samples on the falling edge and compares each pulse against the head of the queue. Any pulse with nothing queued, including a second cycle of a pulse, counts as a failure. Each phase ends with a check that every queued pulse has arrived.

// File: rtl/cwdt_pkg.sv
package cwdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    // control register bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_SUSP  = 1;
    localparam int CTL_FORCE = 2;
endpackage

// File: rtl/cwdt_split_counter.sv
module cwdt_split_counter #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            adv_i,
    output logic [LO_W-1:0] lo_o,
    output logic [HI_W-1:0] hi_o,
    output logic            wrap_o
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (adv_i) begin
            lo_q <= lo_q + 1'b1;
            if (&lo_q) hi_q <= hi_q + 1'b1;
        end
    end

    assign lo_o   = lo_q;
    assign hi_o   = hi_q;
    assign wrap_o = adv_i && (&lo_q);

    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> ($stable(lo_q) && $stable(hi_q)));
    // R2
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (lo_q == '0));
endmodule

// File: rtl/cwdt_match.sv
module cwdt_match #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] offs_i,
    input  logic [W-1:0] hi_i,
    output logic         hit_o
);
    logic [W-1:0] match_q;
    logic [W-1:0] sum;

    assign sum = base_i + offs_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)       match_q <= '0;
        else if (load_i) match_q <= sum;
    end

    assign hit_o = (match_q == hi_i);

    // R3
    match_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(match_q));
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog #(
    parameter int LO_W   = 8,
    parameter int HI_W   = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              idle_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic              wdt_rst_o
);
    import cwdt_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OFFS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(2);

    wd_state_e       state_q, state_d;
    logic            susp_q;
    logic [HI_W-1:0] offs_q;
    logic            rst_q;

    logic            wr_ctrl, wr_offs, wr_kick;
    logic            adv, wrap, hit, expire;
    logic            req_off, req_force;
    logic [LO_W-1:0] lo;
    logic [HI_W-1:0] hi;

    assign wr_ctrl   = bus_wr_i && (bus_addr_i == A_CTRL);
    assign wr_offs   = bus_wr_i && (bus_addr_i == A_OFFS);
    assign wr_kick   = bus_wr_i && (bus_addr_i == A_KICK);
    assign req_off   = wr_ctrl && !bus_wdata_i[CTL_EN];
    assign req_force = wr_ctrl && bus_wdata_i[CTL_EN] && bus_wdata_i[CTL_FORCE];

    // settings registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            susp_q <= 1'b0;
            offs_q <= '0;
        end else begin
            if (wr_ctrl) susp_q <= bus_wdata_i[CTL_SUSP];
            if (wr_offs) offs_q <= bus_wdata_i[HI_W-1:0];
        end
    end

    assign adv = tick_i && !(susp_q && idle_i);

    cwdt_split_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (adv),
        .lo_o   (lo),
        .hi_o   (hi),
        .wrap_o (wrap)
    );

    cwdt_match #(.W(HI_W)) u_match (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (wr_kick),
        .base_i (hi),
        .offs_i (offs_q),
        .hi_i   (hi),
        .hit_o  (hit)
    );

    assign expire = wrap && hit;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= WD_ARMED;
        else       state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (wr_ctrl && bus_wdata_i[CTL_EN]) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (req_off)                    state_d = WD_OFF;
                else if (expire || req_force)   state_d = WD_FIRE;
            end
            WD_FIRE: begin
                if (req_off) state_d = WD_OFF;
                else         state_d = WD_ARMED;
            end
            default: state_d = WD_OFF;
        endcase
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (rst_i) rst_q <= 1'b0;
        else       rst_q <= (state_d == WD_FIRE);
    end

    assign wdt_rst_o = rst_q;

    // R9
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |=> !wdt_rst_o);
    // R7
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WD_OFF) |=> !wdt_rst_o);
    // R6
    force_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WD_ARMED && req_force) |=> wdt_rst_o);
    // R4
    expire_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == WD_ARMED && expire && !req_off) |=> wdt_rst_o);
    // R8
    susp_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (susp_q && idle_i) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: tb/sim_cmp_watchdog.sv
module sim_cmp_watchdog;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       idle = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       wdt_rst;

    int  cyc = 0, cnt_m = 0, off_m = 0, phase = 0;
    bit  susp_m = 1'b0, sparse = 1'b0, finished = 1'b0;
    int  checks = 0, errors = 0;
    int    q_val[$];
    bit    q_tick[$];
    string q_tag[$];

    always #5 clk = ~clk;

    cmp_watchdog u0 (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .idle_i(idle),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .wdt_rst_o(wdt_rst)
    );

    // bench-side tick accounting (R2, R8)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            cnt_m  <= 0;
            susp_m <= 1'b0;
        end else begin
            if (tick && !(susp_m && idle)) cnt_m <= cnt_m + 1;
            if (bus_wr && bus_addr == 2'd0) susp_m <= bus_wdata[1];
        end
    end

    always @(negedge clk) begin
        phase <= (phase == 2) ? 0 : phase + 1;
        tick  <= sparse ? (phase == 0) : 1'b1;
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && wdt_rst) begin
            if (q_val.size() == 0) begin
                chk(1'b0, "R7/R9 unexpected pulse", cyc, -1);
            end else begin
                automatic int    v = q_val.pop_front();
                automatic bit    t = q_tick.pop_front();
                automatic string g = q_tag.pop_front();
                chk((t ? cnt_m : cyc) == v, g, t ? cnt_m : cyc, v);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // kick with an expected deadline in ticks (R3, R5)
    task automatic kick(string tag);
        @(negedge clk);
        begin
            automatic int c = cnt_m;
            q_val.delete(); q_tick.delete(); q_tag.delete();
            q_val.push_back(c + 256 * off_m + 256 - (c % 256));
            q_tick.push_back(1'b1);
            q_tag.push_back(tag);
            bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h5A;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic force_fire(string tag);
        @(negedge clk);
        q_val.push_back(cyc + 1); q_tick.push_back(1'b0); q_tag.push_back(tag);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h05;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drain(int n, string tag);
        repeat (n) @(negedge clk);
        chk(q_val.size() == 0, tag, q_val.size(), 0);
    endtask

    initial begin
        // R1 reset: output low during reset
        begin
            automatic bit seen = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if (wdt_rst !== 1'b0) seen = 1'b1;
            end
            chk(!seen, "R1 pulse low in reset", int'(seen), 0);
        end
        q_val.push_back(256); q_tick.push_back(1'b1); q_tag.push_back("R1 first pulse at tick 256");
        rst = 1'b0;
        drain(300, "R1 reset-default pulse delivered");

        // R7: disabled, kick and force ignored
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h04);
        drain(600, "R7 no pulse while disabled");

        // R3 R5 R10: offset 2, enable, kick
        wr(2'd1, 8'd2); off_m = 2;
        wr(2'd0, 8'h01);
        kick("R5 timeout offset 2");
        drain(900, "R5 offset-2 pulse delivered");

        // R3: re-kick replaces deadline
        kick("R3 first kick");
        repeat (300) @(negedge clk);
        kick("R3 re-kick deadline");
        drain(900, "R3 re-kick pulse delivered");

        // R6: force while enabled
        force_fire("R6 force pulse next cycle");
        drain(5, "R6 force pulse delivered");

        // R8: suspend with idle high
        wr(2'd1, 8'd0); off_m = 0;
        wr(2'd0, 8'h03);
        kick("R8 suspended deadline");
        idle = 1'b1;
        repeat (1000) @(negedge clk);
        idle = 1'b0;
        drain(400, "R8 suspended pulse delivered");

        // R8: idle has no effect without suspend bit
        wr(2'd0, 8'h01);
        kick("R8 idle ignored without suspend");
        idle = 1'b1;
        drain(400, "R8 unsuspended pulse delivered");
        idle = 1'b0;

        // R2 R10: sparse ticks, address 3 write ignored
        sparse = 1'b1;
        wr(2'd3, 8'hFF);
        kick("R2 sparse-tick timeout");
        wr(2'd3, 8'hFF);
        drain(1000, "R10 R2 sparse pulse delivered");
        sparse = 1'b0;

        // R9: whole run had only single-cycle pulses (monitor); finish quiet
        wr(2'd0, 8'h00);
        drain(20, "R9 no trailing pulse");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule